// File: doc/BRIEF.md
# Host RAM and Register Arbiter

This block sits between a host processor and a shared word-wide memory that a serial-bus protocol engine also uses. The host sees an SRAM-like port: chip select, a read/write line, output enable, an address bus and a data bus. A separate register-select line steers the same strobes to two internal registers instead of the memory. No address decode is involved. A host write with that line high loads a write-only control word. A host read with that line high returns a read-only status word.

The protocol engine announces ahead of time that it will need the memory, using a one-cycle notice pulse. The block then raises a busy warning to the host. After a lead time, chosen by one control bit, it hands the memory port to the engine. The port stays with the engine until the engine releases it. While the busy warning is up, host memory accesses are discarded and host memory reads return zero. The registers stay reachable during that time. All host reads, register or memory, return data with the same two-cycle latency. The memory array itself sits outside the block and has a one-cycle synchronous read.

Top module: `host_ram_arbiter`

## Requirements
- R1: After reset, ctrl_o is 0, rbusy_o is 0, eng_grant_o is 0 and host_rvalid_o is 0.
- R2: A host cycle with host_cs_i=1, host_rw_i=0 (write) and host_reg_i=1 loads ctrl_o with host_wdata_i[CTRL_W-1:0] at the next rising edge. It drives neither ram_we_o nor ram_re_o.
- R3: A host cycle with host_cs_i=1, host_rw_i=1 (read), host_oe_i=1 and host_reg_i=1 returns the held status word on host_rdata_o. host_rvalid_o is high for one cycle after the second rising edge following the request. The held status word is status_i registered once.
- R4: A read strobe with host_oe_i=0, or any strobe with host_cs_i=0, causes no register load, no memory access and no host_rvalid_o.
- R5: While rbusy_o is 0, a host memory write (host_reg_i=0) drives ram_we_o, ram_addr_o and ram_wdata_o in the same cycle. A host memory read drives ram_re_o in the same cycle and returns ram_rdata_i with the R3 latency.
- R6: An eng_notice_i pulse sampled while idle raises rbusy_o at that edge. eng_grant_o then rises exactly LEAD_LONG cycles later when ctrl_o[LEAD_SEL_BIT]=0, and LEAD_SHORT cycles later when that bit is 1.
- R7: eng_grant_o implies rbusy_o. Both stay high until an edge samples eng_release_i=1, and both fall at that edge.
- R8: While rbusy_o is 1, host memory writes are dropped and memory contents are unchanged. Host memory reads return 0 with the R3 latency.
- R9: Register writes and register reads behave as in R2 and R3 while rbusy_o is 1.
- R10: While eng_grant_o is 1, ram_addr_o, ram_we_o, ram_re_o and ram_wdata_o follow the engine inputs, and eng_rdata_o equals ram_rdata_i.
- R11: An eng_notice_i during the lead or the grant does not restart the lead. An eng_release_i while not granted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_cs_i | input | 1 | Host chip select |
| host_rw_i | input | 1 | 1 = read, 0 = write |
| host_oe_i | input | 1 | Host output enable, required for reads |
| host_reg_i | input | 1 | Selects registers instead of memory |
| host_addr_i | input | ADDR_W | Host memory address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data |
| host_rvalid_o | output | 1 | Read data valid strobe |
| rbusy_o | output | 1 | Busy warning to host |
| ctrl_o | output | CTRL_W | Control register contents |
| status_i | input | DATA_W | Status word source |
| eng_notice_i | input | 1 | Engine advance-notice pulse |
| eng_release_i | input | 1 | Engine releases memory port |
| eng_grant_o | output | 1 | Memory port granted to engine |
| eng_addr_i | input | ADDR_W | Engine memory address |
| eng_we_i | input | 1 | Engine write enable |
| eng_re_i | input | 1 | Engine read enable |
| eng_wdata_i | input | DATA_W | Engine write data |
| eng_rdata_o | output | DATA_W | Engine read data |
| ram_addr_o | output | ADDR_W | Memory address |
| ram_we_o | output | 1 | Memory write enable |
| ram_re_o | output | 1 | Memory read enable |
| ram_wdata_o | output | DATA_W | Memory write data |
| ram_rdata_i | input | DATA_W | Memory read data, one cycle after ram_re_o |

## Verification
The bench keeps the default 10-bit address and 13-bit control widths. It shortens the lead times to LEAD_LONG=6 and LEAD_SHORT=3, so both lead paths and the whole busy cycle fit in a few dozen clocks. With the short leads, all 8192 control values can be written in turn, along with a sweep of status words and a block of memory addresses. Each lead is measured cycle by cycle, and dropped writes during busy are checked by reading memory back after release.

// File: rtl/host_arb_pkg.sv
package host_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_GRANT} busy_st_e;
  typedef enum logic [1:0] {RD_NONE, RD_REG, RD_RAM, RD_BLK} rd_kind_e;
endpackage

// File: rtl/host_busy_fsm.sv
module host_busy_fsm
  import host_arb_pkg::*;
#(
  parameter int LEAD_LONG  = 68,
  parameter int LEAD_SHORT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_sel_i,
  input  logic notice_i,
  input  logic release_i,
  output logic busy_o,
  output logic grant_o
);
  localparam int LeadMax = (LEAD_LONG > LEAD_SHORT) ? LEAD_LONG : LEAD_SHORT;
  localparam int CntW    = $clog2(LeadMax + 1);
  localparam logic [CntW-1:0] LongLd  = CntW'(LEAD_LONG - 1);
  localparam logic [CntW-1:0] ShortLd = CntW'(LEAD_SHORT - 1);

  busy_st_e      st_q;
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (notice_i) begin
          st_q  <= ST_LEAD;
          cnt_q <= lead_sel_i ? ShortLd : LongLd;
        end
        ST_LEAD: begin
          if (cnt_q == '0) st_q <= ST_GRANT;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_GRANT: if (release_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign grant_o = (st_q == ST_GRANT);
endmodule

// File: rtl/host_reg_file.sv
module host_reg_file #(
  parameter int DATA_W       = 16,
  parameter int CTRL_W       = 13,
  parameter int LEAD_SEL_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] status_o,
  output logic              lead_sel_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= status_i;
      if (wr_i) ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  assign ctrl_o     = ctrl_q;
  assign status_o   = stat_q;
  assign lead_sel_o = ctrl_q[LEAD_SEL_BIT];
endmodule

// File: rtl/host_ram_mux.sv
module host_ram_mux
  import host_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              grant_i,
  input  logic              h_we_i,
  input  logic              h_re_i,
  input  logic              h_reg_rd_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [ADDR_W-1:0] e_addr_i,
  input  logic              e_we_i,
  input  logic              e_re_i,
  input  logic [DATA_W-1:0] e_wdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  rd_kind_e          kind_q;
  logic [DATA_W-1:0] snap_q, rdata_q;
  logic              rvalid_q;

  always_comb begin
    ram_addr_o  = h_addr_i;
    ram_wdata_o = h_wdata_i;
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    if (grant_i) begin
      ram_addr_o  = e_addr_i;
      ram_wdata_o = e_wdata_i;
      ram_we_o    = e_we_i;
      ram_re_o    = e_re_i;
    end else if (!busy_i) begin
      ram_we_o = h_we_i;
      ram_re_o = h_re_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q   <= RD_NONE;
      snap_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      snap_q <= status_i;
      if (h_reg_rd_i)  kind_q <= RD_REG;
      else if (h_re_i) kind_q <= busy_i ? RD_BLK : RD_RAM;
      else             kind_q <= RD_NONE;
      rvalid_q <= (kind_q != RD_NONE);
      unique case (kind_q)
        RD_REG:  rdata_q <= snap_q;
        RD_RAM:  rdata_q <= ram_rdata_i;
        RD_BLK:  rdata_q <= '0;
        default: rdata_q <= rdata_q;
      endcase
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/host_ram_arbiter.sv
module host_ram_arbiter
  import host_arb_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 16,
  parameter int CTRL_W       = 13,
  parameter int LEAD_SEL_BIT = 7,
  parameter int LEAD_LONG    = 68,
  parameter int LEAD_SHORT   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_i,
  input  logic              host_rw_i,
  input  logic              host_oe_i,
  input  logic              host_reg_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  output logic              rbusy_o,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [DATA_W-1:0] status_i,
  input  logic              eng_notice_i,
  input  logic              eng_release_i,
  output logic              eng_grant_o,
  input  logic [ADDR_W-1:0] eng_addr_i,
  input  logic              eng_we_i,
  input  logic              eng_re_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  output logic [DATA_W-1:0] eng_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic rd_strb, wr_strb, reg_wr, reg_rd, mem_wr, mem_rd;
  logic lead_sel, busy, grant;
  logic [DATA_W-1:0] stat_held;

  assign rd_strb = host_cs_i & host_rw_i & host_oe_i;
  assign wr_strb = host_cs_i & ~host_rw_i;
  assign reg_wr  = wr_strb & host_reg_i;
  assign reg_rd  = rd_strb & host_reg_i;
  assign mem_wr  = wr_strb & ~host_reg_i;
  assign mem_rd  = rd_strb & ~host_reg_i;

  host_reg_file #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LEAD_SEL_BIT(LEAD_SEL_BIT)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr), .wdata_i(host_wdata_i), .status_i(status_i),
    .ctrl_o(ctrl_o), .status_o(stat_held), .lead_sel_o(lead_sel)
  );

  host_busy_fsm #(
    .LEAD_LONG(LEAD_LONG), .LEAD_SHORT(LEAD_SHORT)
  ) u_busy (
    .clk_i, .rst_ni,
    .lead_sel_i(lead_sel), .notice_i(eng_notice_i), .release_i(eng_release_i),
    .busy_o(busy), .grant_o(grant)
  );

  host_ram_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_mux (
    .clk_i, .rst_ni,
    .busy_i(busy), .grant_i(grant),
    .h_we_i(mem_wr), .h_re_i(mem_rd), .h_reg_rd_i(reg_rd),
    .h_addr_i(host_addr_i), .h_wdata_i(host_wdata_i), .status_i(stat_held),
    .e_addr_i(eng_addr_i), .e_we_i(eng_we_i), .e_re_i(eng_re_i), .e_wdata_i(eng_wdata_i),
    .ram_addr_o, .ram_we_o, .ram_re_o, .ram_wdata_o, .ram_rdata_i,
    .rdata_o(host_rdata_o), .rvalid_o(host_rvalid_o)
  );

  assign rbusy_o     = busy;
  assign eng_grant_o = grant;
  assign eng_rdata_o = ram_rdata_i;
endmodule

// File: rtl/host_ram_arbiter_chk.sv
module host_ram_arbiter_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int CTRL_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_cs_i,
  input logic              host_rw_i,
  input logic              host_oe_i,
  input logic              host_reg_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic              host_rvalid_o,
  input logic              rbusy_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              eng_notice_i,
  input logic              eng_release_i,
  input logic              eng_grant_o,
  input logic [ADDR_W-1:0] eng_addr_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              ram_re_o
);
  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cs_i && !host_rw_i && host_reg_i |=> ctrl_o == $past(host_wdata_i[CTRL_W-1:0])); // R2
  AST_REG_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_grant_o && host_cs_i && host_reg_i |-> !ram_we_o && !ram_re_o); // R2
  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cs_i && host_rw_i && host_oe_i |=> ##1 host_rvalid_o); // R3
  AST_NO_CS_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_grant_o && !host_cs_i |-> !ram_we_o && !ram_re_o); // R4
  AST_BUSY_FROM_NOTICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rbusy_o) |-> $past(eng_notice_i)); // R6
  AST_GRANT_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_grant_o |-> rbusy_o); // R7
  AST_RELEASE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_grant_o && eng_release_i |=> !rbusy_o && !eng_grant_o); // R7
  AST_BUSY_NO_HOST_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbusy_o && !eng_grant_o |-> !ram_we_o && !ram_re_o); // R8
  AST_ENGINE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_grant_o |-> ram_addr_o == eng_addr_i); // R10
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_grant_o && !eng_release_i |=> eng_grant_o); // R11
endmodule

bind host_ram_arbiter host_ram_arbiter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk_i, .rst_ni, .host_cs_i, .host_rw_i, .host_oe_i, .host_reg_i, .host_wdata_i,
  .host_rvalid_o, .rbusy_o, .ctrl_o, .eng_notice_i, .eng_release_i, .eng_grant_o,
  .eng_addr_i, .ram_addr_o, .ram_we_o, .ram_re_o
);

// File: tb/host_ram_arbiter_tb.sv
module host_ram_arbiter_tb;
  localparam int ClkPeriod = 10;
  localparam int AW = 10, DW = 16, CW = 13, SEL = 7, LL = 6, LS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rw = 0, oe = 0, rsel = 0;
  logic [AW-1:0] addr = '0, e_addr = '0;
  logic [DW-1:0] wdata = '0, status = '0, e_wdata = '0, rdata, e_rdata, r_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic rvalid, rbusy, grant, notice = 0, rel = 0, e_we = 0, e_re = 0;
  logic [CW-1:0] ctrl;
  logic [AW-1:0] r_addr;
  logic r_we, r_re;
  logic [DW-1:0] mem [1<<AW];
  int errors = 0, checks = 0;

  always #(ClkPeriod/2) clk = ~clk;

  host_ram_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW), .LEAD_SEL_BIT(SEL),
    .LEAD_LONG(LL), .LEAD_SHORT(LS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_i(cs), .host_rw_i(rw), .host_oe_i(oe),
    .host_reg_i(rsel), .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .host_rvalid_o(rvalid), .rbusy_o(rbusy), .ctrl_o(ctrl), .status_i(status),
    .eng_notice_i(notice), .eng_release_i(rel), .eng_grant_o(grant),
    .eng_addr_i(e_addr), .eng_we_i(e_we), .eng_re_i(e_re), .eng_wdata_i(e_wdata),
    .eng_rdata_o(e_rdata), .ram_addr_o(r_addr), .ram_we_o(r_we), .ram_re_o(r_re),
    .ram_wdata_o(r_wdata), .ram_rdata_i(ram_rdata));

  always @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (r_re) ram_rdata <= mem[r_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle host strobe, returns at the negedge after the sampling edge
  task automatic host(input bit r, input bit w_n, input bit o, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    cs = 1; rsel = r; rw = w_n; oe = o; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; rw = 0; oe = 0; rsel = 0;
  endtask

  task automatic host_read(input bit r, input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output bit v);
    host(r, 1, 1, a, '0);
    @(negedge clk);
    d = rdata; v = rvalid;
  endtask

  task automatic pulse_notice();
    notice = 1; @(negedge clk); notice = 0;
  endtask

  task automatic release_port();
    rel = 1; @(negedge clk); rel = 0;
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    bit v;
    int n;
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(ctrl == 0 && !rbusy && !grant && !rvalid, "R1", {ctrl, rbusy, grant, rvalid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl == 0 && !rbusy && !grant && !rvalid, "R1 after release", {ctrl, rbusy, grant}, 0);

    // R2 sweep all control values, upper bits garbage
    for (int c = 0; c < (1<<CW); c++) begin
      host(1, 0, 0, '0, DW'({c[2:0], c[CW-1:0]}) ^ DW'(16'hE000 & (c << 3)));
      chk(ctrl == CW'(c), "R2", ctrl, c);
    end
    host(1, 0, 0, '0, '0);
    chk(r_we == 0, "R2 no ram write", r_we, 0);

    // R3 status sweep
    for (int s = 0; s < 256; s++) begin
      status = DW'(s * 257 ^ 16'h5A3C);
      @(negedge clk);
      host_read(1, '0, d, v);
      chk(v && d == DW'(s * 257 ^ 16'h5A3C), "R3", d, s * 257 ^ 16'h5A3C);
    end

    // R5 memory write/read sweep while idle
    for (int a = 0; a < 64; a++) begin
      host(0, 0, 0, AW'(a * 13 + 1), DW'(a * 977 + 3));
      chk(mem[AW'(a * 13 + 1)] == DW'(a * 977 + 3), "R5 write", mem[AW'(a * 13 + 1)], a * 977 + 3);
    end
    for (int a = 0; a < 64; a++) begin
      host_read(0, AW'(a * 13 + 1), d, v);
      chk(v && d == DW'(a * 977 + 3), "R5 read", d, a * 977 + 3);
    end

    // R4 oe low and cs low
    host(1, 1, 0, '0, '0);
    chk(!rvalid, "R4 oe low", rvalid, 0);
    @(negedge clk);
    chk(!rvalid, "R4 oe low late", rvalid, 0);
    rsel = 1; rw = 0; wdata = 16'h1FFF; @(negedge clk); rsel = 0;
    chk(ctrl == 0, "R4 cs low", ctrl, 0);
    addr = 10'd1; wdata = 16'hDEAD; @(negedge clk);
    host_read(0, 10'd1, d, v);
    chk(d == 16'd3, "R4 cs low no mem write", d, 3);

    // R6 long lead (ctrl bit SEL = 0), R11 repeat notice
    pulse_notice();
    chk(rbusy && !grant, "R6 busy rise", {rbusy, grant}, 2);
    n = 0;
    while (!grant && n < 200) begin
      if (n == 1) notice = 1;
      @(negedge clk); notice = 0; n++;
    end
    chk(n == LL, "R6 long lead", n, LL);
    chk(n == LL, "R11 notice in lead ignored", n, LL);

    // R10 engine owns port
    e_addr = 10'd500; e_wdata = 16'hBEEF; e_we = 1; @(negedge clk); e_we = 0;
    chk(mem[10'd500] == 16'hBEEF, "R10 engine write", mem[10'd500], 16'hBEEF);
    e_re = 1; e_addr = 10'd14; @(negedge clk); e_re = 0;
    chk(e_rdata == 16'd980, "R10 engine read", e_rdata, 980);
    // R8 host blocked while granted
    host(0, 0, 0, 10'd1, 16'h7777);
    chk(mem[10'd1] == 16'd3, "R8 write dropped", mem[10'd1], 3);
    host_read(0, 10'd1, d, v);
    chk(v && d == 0, "R8 read zero", d, 0);
    // R9 registers during busy
    host(1, 0, 0, '0, DW'(1 << SEL));
    chk(ctrl == CW'(1 << SEL), "R9 write", ctrl, 1 << SEL);
    status = 16'hA5C3; @(negedge clk);
    host_read(1, '0, d, v);
    chk(v && d == 16'hA5C3, "R9 read", d, 16'hA5C3);
    chk(rbusy && grant, "R7 held", {rbusy, grant}, 3);
    release_port();
    chk(!rbusy && !grant, "R7 release", {rbusy, grant}, 0);
    host_read(0, 10'd1, d, v);
    chk(d == 16'd3, "R8 memory unchanged", d, 3);

    // R11 release while idle
    release_port();
    chk(!rbusy && !grant, "R11 stray release", {rbusy, grant}, 0);

    // R6 short lead, R8 during lead
    pulse_notice();
    host(0, 0, 0, 10'd14, 16'h1234);
    chk(mem[10'd14] == 16'd980, "R8 dropped in lead", mem[10'd14], 980);
    n = 1;
    while (!grant && n < 200) begin @(negedge clk); n++; end
    chk(n == LS, "R6 short lead", n, LS);
    release_port();
    chk(!rbusy, "R7 second release", rbusy, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule